// File: doc/BRIEF.md
# Trimmed Calendar Timekeeping Counter

This block keeps wall-clock time (seconds, minutes, hours) and a calendar (date, month, two-digit year, day of week), all as packed BCD. It advances on a clock-enable pulse train, with one enable pulse for each cycle of a 32.768 kHz oscillator. A sub-second divider counts these pulses and moves the seconds field on by one each time a full second has been counted.

A 3-bit signed trim code corrects the rate in 20 ppm steps. Once in every minute, the second in which the seconds field reads 59 is made shorter or longer by a whole number of oscillator pulses. The leap-year rule is a plain divisible-by-four test on the two-digit year, which is correct for years 2000 to 2099.

Software sets the time through a single-cycle load strobe. The strobe writes every field at once and restarts the sub-second divider.

Top module: `rtc_trim_calendar`

## Requirements
- R1: While reset is asserted, the outputs read 00:00:00 on date 01, month 01, year 00, day of week 0.
- R2: When `load_en` is high at a clock edge, all seven fields take the load values and the divider restarts from zero, even if `tick_en` is high in that cycle. An untrimmed second then lasts exactly DIV_COUNT tick-enabled edges.
- R3: An edge with `tick_en` low changes no field and does not advance the divider. Ticks spread over more clock cycles give the same count as back-to-back ticks.
- R4: Seconds and minutes count 00 to 59, and hours count 00 to 23, in BCD (for example 09 is followed by 10). Each field wraps to 00 and carries into the next field up. The hour wrap advances the day.
- R5: Day of week counts 0 to 6 and returns to 0 after 6, once on each day advance.
- R6: Months 04, 06, 09 and 11 have 30 days, and all other months except 02 have 31. After the last day, the date returns to 01 and the month advances. After month 12, the month returns to 01 and the year advances. Year 99 is followed by year 00.
- R7: Month 02 has 29 days when the two-digit year is divisible by 4 (year 00 included) and 28 days otherwise.
- R8: `trim_code[2]`=1 means add and 0 means skip, and `trim_code[1:0]` is the step count n. The second during which the seconds field reads 59 lasts DIV_COUNT − n·TRIM_STEP ticks when adding and DIV_COUNT + n·TRIM_STEP ticks when skipping. Codes 000 and 100 leave it at DIV_COUNT.
- R9: Every second whose seconds field is not 59 lasts DIV_COUNT ticks, whatever the trim code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One pulse for each oscillator cycle |
| trim_code | input | 3 | Sign (bit 2: 1 add, 0 skip) and step count (bits 1:0) |
| load_en | input | 1 | Load strobe for all fields |
| load_sec | input | 8 | BCD seconds to load |
| load_min | input | 8 | BCD minutes to load |
| load_hour | input | 8 | BCD hours to load |
| load_date | input | 8 | BCD date to load |
| load_month | input | 8 | BCD month to load |
| load_year | input | 8 | BCD year to load |
| load_dow | input | 3 | Day of week to load |
| sec | output | 8 | BCD seconds |
| min | output | 8 | BCD minutes |
| hour | output | 8 | BCD hours |
| date | output | 8 | BCD date |
| month | output | 8 | BCD month |
| year | output | 8 | BCD year |
| dow | output | 3 | Day of week |

## Verification
A wrong divider count shows up as a seconds change one or more ticks early or late, so the bench samples one tick before and exactly at each expected boundary. A wrong trim length is confined to the second at 59: the check measures that second alone and also one whole minute. Wrong month lengths or a wrong leap test stay hidden until the next day advance. Each calendar case therefore loads 23:59:59 on the critical date and looks at the fields one second later.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Add one to a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction

  // (10*tens + units) mod 4 equals (2*tens + units) mod 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] m4;
    m4 = {yr[4], 1'b0} + yr[1:0];
    return (m4 == 2'd0);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon,
                                             input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_trim_div.sv
module rtc_trim_div #(
  parameter int DIV_COUNT = 32768,
  parameter int TRIM_STEP = 39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       clear,
  input  logic [2:0] trim_code,
  input  logic       last_sec,
  output logic       sec_pulse
);
  localparam int MAX_LEN = DIV_COUNT + 3 * TRIM_STEP;
  localparam int CW      = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] BASE   = CW'(DIV_COUNT);
  localparam logic [CW-1:0] STEP_W = CW'(TRIM_STEP);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, adj, len;
  logic          at_end, cnt_en;

  always_comb begin
    adj = CW'(trim_code[1:0]) * STEP_W;
    if (!last_sec)         len = BASE;
    else if (trim_code[2]) len = BASE - adj;
    else                   len = BASE + adj;
  end

  assign at_end    = (cnt_q >= len - ONE);
  assign sec_pulse = tick_en & ~clear & at_end;
  assign cnt_en    = clear | tick_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (at_end)  cnt_d = '0;
    else              cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R2
  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clear) |=> $stable(cnt_q)); // R3
  AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  output logic [7:0] val,
  output logic       carry
);
  logic [7:0] val_q, val_d;
  logic       at_top, upd;

  assign at_top = (val_q == hi);
  assign upd    = load | inc;
  assign carry  = inc & ~load & at_top;
  assign val    = val_q;

  always_comb begin
    val_d = val_q;
    if (load)     val_d = load_val;
    else if (inc) val_d = at_top ? lo : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val_q <= RST_VAL;
    else if (upd) val_q <= val_d;
  end

  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val_q == $past(load_val))); // R2
  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && val_q == hi) |=> (val_q == $past(lo))); // R4
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(val_q)); // R3

endmodule

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_adv,
  input  logic       load,
  input  logic [7:0] load_date,
  input  logic [7:0] load_month,
  input  logic [7:0] load_year,
  input  logic [2:0] load_dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [2:0] dow
);
  logic [7:0] last_day;
  logic       date_cry, mon_cry, yr_cry;
  logic [2:0] dow_q, dow_d;
  logic       dow_en;

  assign last_day = month_last(month, year);

  rtc_bcd_wrap #(.RST_VAL(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .inc(day_adv), .load(load), .load_val(load_date),
    .lo(8'h01), .hi(last_day), .val(date), .carry(date_cry));

  rtc_bcd_wrap #(.RST_VAL(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .inc(date_cry), .load(load), .load_val(load_month),
    .lo(8'h01), .hi(8'h12), .val(month), .carry(mon_cry));

  rtc_bcd_wrap #(.RST_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(mon_cry), .load(load), .load_val(load_year),
    .lo(8'h00), .hi(8'h99), .val(year), .carry(yr_cry));

  assign dow_en = load | day_adv;
  assign dow    = dow_q;

  always_comb begin
    dow_d = dow_q;
    if (load)               dow_d = load_dow;
    else if (dow_q >= 3'd6) dow_d = 3'd0;
    else                    dow_d = dow_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dow_q <= 3'd0;
    else if (dow_en) dow_q <= dow_d;
  end

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !load && dow_q == 3'd6) |=> (dow_q == 3'd0)); // R5
  AST_LEAP_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !load && month == 8'h02 && date == 8'h28 && year[1:0] == 2'b00
     && year[4] == 1'b0) |=> (date == 8'h29)); // R7
  AST_CENTURY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    yr_cry |=> (year == 8'h00 && month == 8'h01 && date == 8'h01)); // R6

endmodule

// File: rtl/rtc_trim_calendar.sv
module rtc_trim_calendar #(
  parameter int DIV_COUNT = 32768,
  parameter int TRIM_STEP = 39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] trim_code,
  input  logic       load_en,
  input  logic [7:0] load_sec,
  input  logic [7:0] load_min,
  input  logic [7:0] load_hour,
  input  logic [7:0] load_date,
  input  logic [7:0] load_month,
  input  logic [7:0] load_year,
  input  logic [2:0] load_dow,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [2:0] dow
);
  localparam int NFIELD = 3;

  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic       sec_pulse;
  logic [7:0] t_val  [NFIELD];
  logic [7:0] t_load [NFIELD];
  logic       t_inc  [NFIELD];
  logic       t_cry  [NFIELD];

  rtc_trim_div #(.DIV_COUNT(DIV_COUNT), .TRIM_STEP(TRIM_STEP)) u_div (
    .clk(clk), .rst_n(rst_n_s), .tick_en(tick_en), .clear(load_en),
    .trim_code(trim_code), .last_sec(t_val[0] == 8'h59), .sec_pulse(sec_pulse));

  assign t_load[0] = load_sec;
  assign t_load[1] = load_min;
  assign t_load[2] = load_hour;
  assign t_inc[0]  = sec_pulse;

  generate
    for (genvar i = 0; i < NFIELD; i++) begin : g_time
      localparam logic [7:0] TOP = (i == NFIELD - 1) ? 8'h23 : 8'h59;
      if (i > 0) begin : g_link
        assign t_inc[i] = t_cry[i-1];
      end
      rtc_bcd_wrap #(.RST_VAL(8'h00)) u_field (
        .clk(clk), .rst_n(rst_n_s), .inc(t_inc[i]), .load(load_en),
        .load_val(t_load[i]), .lo(8'h00), .hi(TOP),
        .val(t_val[i]), .carry(t_cry[i]));
    end
  endgenerate

  assign sec  = t_val[0];
  assign min  = t_val[1];
  assign hour = t_val[2];

  rtc_cal_chain u_cal (
    .clk(clk), .rst_n(rst_n_s), .day_adv(t_cry[NFIELD-1]), .load(load_en),
    .load_date(load_date), .load_month(load_month), .load_year(load_year),
    .load_dow(load_dow), .date(date), .month(month), .year(year), .dow(dow));

  AST_SEC_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tick_en && !load_en) |=> $stable(sec)); // R3
  AST_MIDNIGHT_ROLL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (t_cry[NFIELD-1]) |=> (sec == 8'h00 && min == 8'h00 && hour == 8'h00)); // R4

endmodule

// File: tb/rtc_trim_calendar_bench.sv
module rtc_trim_calendar_bench;
  localparam int DIV  = 16;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, load_en;
  logic [2:0] trim_code, load_dow, dow;
  logic [7:0] load_sec, load_min, load_hour, load_date, load_month, load_year;
  logic [7:0] sec, min, hour, date, month, year;

  int n_cmp  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  rtc_trim_calendar #(.DIV_COUNT(DIV), .TRIM_STEP(STEP)) u_rtc_trim_calendar (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trim_code(trim_code),
    .load_en(load_en), .load_sec(load_sec), .load_min(load_min),
    .load_hour(load_hour), .load_date(load_date), .load_month(load_month),
    .load_year(load_year), .load_dow(load_dow), .sec(sec), .min(min),
    .hour(hour), .date(date), .month(month), .year(year), .dow(dow));

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  trim;
    logic [15:0] ticks;
    logic [50:0] start;  // sec min hour date month year dow
    logic [50:0] expect_v;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 3'd0, 16'd15,  {8'h56,8'h34,8'h12,8'h15,8'h06,8'h24,3'd3}, {8'h56,8'h34,8'h12,8'h15,8'h06,8'h24,3'd3}}, // R2
    '{4'd2, 3'd0, 16'd16,  {8'h56,8'h34,8'h12,8'h15,8'h06,8'h24,3'd3}, {8'h57,8'h34,8'h12,8'h15,8'h06,8'h24,3'd3}}, // R2
    '{4'd4, 3'd0, 16'd16,  {8'h59,8'h20,8'h10,8'h10,8'h05,8'h30,3'd2}, {8'h00,8'h21,8'h10,8'h10,8'h05,8'h30,3'd2}}, // R4
    '{4'd4, 3'd0, 16'd16,  {8'h59,8'h59,8'h10,8'h10,8'h05,8'h30,3'd2}, {8'h00,8'h00,8'h11,8'h10,8'h05,8'h30,3'd2}}, // R4
    '{4'd4, 3'd0, 16'd16,  {8'h59,8'h59,8'h09,8'h10,8'h05,8'h30,3'd2}, {8'h00,8'h00,8'h10,8'h10,8'h05,8'h30,3'd2}}, // R4
    '{4'd5, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h30,8'h04,8'h21,3'd6}, {8'h00,8'h00,8'h00,8'h01,8'h05,8'h21,3'd0}}, // R5
    '{4'd6, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h31,8'h01,8'h21,3'd1}, {8'h00,8'h00,8'h00,8'h01,8'h02,8'h21,3'd2}}, // R6
    '{4'd6, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h30,8'h01,8'h21,3'd1}, {8'h00,8'h00,8'h00,8'h31,8'h01,8'h21,3'd2}}, // R6
    '{4'd6, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h30,8'h11,8'h05,3'd3}, {8'h00,8'h00,8'h00,8'h01,8'h12,8'h05,3'd4}}, // R6
    '{4'd6, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h31,8'h12,8'h99,3'd4}, {8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,3'd5}}, // R6
    '{4'd7, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h28,8'h02,8'h24,3'd0}, {8'h00,8'h00,8'h00,8'h29,8'h02,8'h24,3'd1}}, // R7
    '{4'd7, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h29,8'h02,8'h24,3'd1}, {8'h00,8'h00,8'h00,8'h01,8'h03,8'h24,3'd2}}, // R7
    '{4'd7, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h28,8'h02,8'h23,3'd1}, {8'h00,8'h00,8'h00,8'h01,8'h03,8'h23,3'd2}}, // R7
    '{4'd7, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h28,8'h02,8'h00,3'd5}, {8'h00,8'h00,8'h00,8'h29,8'h02,8'h00,3'd6}}, // R7
    '{4'd7, 3'd0, 16'd16,  {8'h59,8'h59,8'h23,8'h28,8'h02,8'h18,3'd5}, {8'h00,8'h00,8'h00,8'h01,8'h03,8'h18,3'd6}}, // R7
    '{4'd8, 3'd7, 16'd9,   {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R8
    '{4'd8, 3'd7, 16'd10,  {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h00,8'h01,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R8
    '{4'd8, 3'd2, 16'd19,  {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R8
    '{4'd8, 3'd2, 16'd20,  {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h00,8'h01,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R8
    '{4'd8, 3'd4, 16'd15,  {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R8
    '{4'd8, 3'd4, 16'd16,  {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h00,8'h01,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R8
    '{4'd9, 3'd7, 16'd15,  {8'h30,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h30,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R9
    '{4'd9, 3'd7, 16'd16,  {8'h30,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h31,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R9
    '{4'd9, 3'd5, 16'd29,  {8'h58,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R9
    '{4'd9, 3'd1, 16'd961, {8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}}, // R9
    '{4'd9, 3'd1, 16'd962, {8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, {8'h00,8'h01,8'h00,8'h01,8'h01,8'h00,3'd0}}  // R9
  };

  function automatic logic [50:0] now_fields();
    return {sec, min, hour, date, month, year, dow};
  endfunction

  task automatic check(input int req, input logic [50:0] exp_v, input string what);
    n_cmp++;
    if (now_fields() !== exp_v) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, now_fields(), exp_v);
    end
  endtask

  task automatic do_load(input logic [50:0] f, input logic tk);
    @(negedge clk);
    {load_sec, load_min, load_hour, load_date, load_month, load_year, load_dow} = f;
    load_en = 1'b1;
    tick_en = tk;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  localparam logic [50:0] RESET_V = {8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; load_en = 1'b0; trim_code = 3'd0;
    {load_sec, load_min, load_hour, load_date, load_month, load_year, load_dow} = '0;
    repeat (3) @(negedge clk);
    check(1, RESET_V, "fields during reset");  // R1
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, RESET_V, "fields after release"); // R1

    for (int i = 0; i < NV; i++) begin
      trim_code = VECS[i].trim;
      do_load(VECS[i].start, 1'b0);
      run_ticks(int'(VECS[i].ticks));
      check(int'(VECS[i].req), VECS[i].expect_v, $sformatf("vector %0d", i));
    end

    // R3: idle tick enable freezes everything
    trim_code = 3'd0;
    do_load({8'h07,8'h06,8'h05,8'h02,8'h03,8'h04,3'd1}, 1'b0);
    repeat (40) @(negedge clk);
    check(3, {8'h07,8'h06,8'h05,8'h02,8'h03,8'h04,3'd1}, "idle hold");
    // R3: sparse ticks, every other cycle
    for (int k = 0; k < 15; k++) begin
      tick_en = 1'b1; @(negedge clk);
      tick_en = 1'b0; @(negedge clk);
    end
    check(3, {8'h07,8'h06,8'h05,8'h02,8'h03,8'h04,3'd1}, "sparse 15 ticks");
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    check(3, {8'h08,8'h06,8'h05,8'h02,8'h03,8'h04,3'd1}, "sparse 16 ticks");

    // R2: load wins over a tick in the same cycle and restarts the divider
    do_load({8'h10,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, 1'b0);
    run_ticks(10);
    do_load({8'h20,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, 1'b1);
    run_ticks(15);
    check(2, {8'h20,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, "reload restart 15");
    run_ticks(1);
    check(2, {8'h21,8'h00,8'h00,8'h01,8'h01,8'h00,3'd0}, "reload restart 16");

    // R1: reset in mid run
    run_ticks(7);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(1, RESET_V, "mid-run reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule